// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is a small 2D pixel engine that sits behind a register write port and in front of a pixel memory. Software loads a fill colour, a raster operation code, a command word, a frame base address, a line pitch and packed corner coordinates. Writing the final destination corner starts the engine. It then walks the destination rectangle one pixel at a time. For each pixel it reads the source and, when needed, the current destination, then writes the combined result back through a request/acknowledge memory port.

Fills take their source value from the colour register. Copies read a second rectangle of the same frame. When source and destination overlap, software picks the walk direction from their relative position and loads the corners in swapped order for a backward walk. Every source pixel is then read before the copy can overwrite it. A busy output tells software when the next operation may be loaded. Register writes that arrive while busy are dropped and raise a sticky error flag.

Top module: `blit_engine`

## Requirements
- R1: A coordinate register word carries x in bits 15:0 and y in bits 31:16.
- R2: Corners are inclusive: an operation from corner (x0,y0) to corner (x1,y1) writes every pixel with x between x0 and x1 and y between y0 and y1 exactly once, and no pixel outside that rectangle.
- R3: Raster code 0xCC, and any code other than 0x66 and 0xF0, writes the source value: the source pixel for a copy, the colour register for a fill.
- R4: Raster code 0x66 writes the source value XOR the destination pixel as it was read just before the write.
- R5: Raster code 0xF0 writes the colour register for both fills and copies.
- R6: Register indices on reg_addr are 0 colour, 1 raster code (bits 7:0), 2 command (bit 0 = copy, bit 1 = backward walk), 3 pitch in pixels, 4 frame base byte address, 5 source first corner, 6 destination first corner, 7 destination second corner. Only a write to index 7 while idle starts an operation. The first memory request follows on the next cycle.
- R7: A forward walk starts at the first corner and steps +1 in x along a row, then +1 in y. A backward walk steps -1 in both. At the end of each row, x returns to the first-corner column. The source walks in step with the destination from its own first corner.
- R8: A pixel at (x,y) is at byte address base + (y*pitch + x)*4.
- R9: busy is high from the cycle after the launching write until the cycle after the final pixel write is acknowledged, and low otherwise.
- R10: A register write while busy changes no register, starts nothing, and sets the err output. err stays set until reset.
- R11: For each pixel the memory sequence is: source read (copy only), then destination read (code 0x66 only), then destination write. Each request holds its address and data until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Sticky flag: write arrived while busy |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge, one cycle |

## Verification
The bench builds the engine with its default parameters: 16-bit coordinates, 4-byte pixels and a 32-bit address. This puts the full packed-coordinate word and the byte address formula in play. Pitch and base are programmed at run time, so one run covers several frame geometries. The bench uses a small frame with narrow rectangles and a responder whose latency varies. This reaches overlapping copies in both walk directions, same-row overlaps on either side, and single-pixel operations. Writes arriving while busy land in the middle of an operation.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam logic [7:0] ROP_SRC = 8'hCC;
  localparam logic [7:0] ROP_XOR = 8'h66;
  localparam logic [7:0] ROP_PAT = 8'hF0;

  localparam logic [3:0] IDX_COLOUR = 4'd0;
  localparam logic [3:0] IDX_ROP    = 4'd1;
  localparam logic [3:0] IDX_CMD    = 4'd2;
  localparam logic [3:0] IDX_PITCH  = 4'd3;
  localparam logic [3:0] IDX_BASE   = 4'd4;
  localparam logic [3:0] IDX_SRC0   = 4'd5;
  localparam logic [3:0] IDX_DST0   = 4'd6;
  localparam logic [3:0] IDX_DST1   = 4'd7;

  localparam int Y_LSB = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_RD_S, ST_RD_D, ST_WR} blit_st_e;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [3:0]         addr,
  input  logic [31:0]        wdata,
  input  logic               busy,
  output logic [DATA_W-1:0]  colour,
  output logic [7:0]         rop,
  output logic               copy_mode,
  output logic               backward,
  output logic [COORD_W-1:0] pitch,
  output logic [ADDR_W-1:0]  base,
  output logic [COORD_W-1:0] sx0,
  output logic [COORD_W-1:0] sy0,
  output logic [COORD_W-1:0] dx0,
  output logic [COORD_W-1:0] dy0,
  output logic [COORD_W-1:0] dx1,
  output logic [COORD_W-1:0] dy1,
  output logic               launch,
  output logic               err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      colour <= '0; rop <= ROP_SRC; copy_mode <= 1'b0; backward <= 1'b0;
      pitch <= '0; base <= '0;
      sx0 <= '0; sy0 <= '0; dx0 <= '0; dy0 <= '0; dx1 <= '0; dy1 <= '0;
      launch <= 1'b0; err <= 1'b0;
    end else begin
      launch <= 1'b0;
      if (we && busy) begin
        err <= 1'b1;
      end else if (we) begin
        case (addr)
          IDX_COLOUR: colour <= wdata[DATA_W-1:0];
          IDX_ROP:    rop <= wdata[7:0];
          IDX_CMD:    {backward, copy_mode} <= wdata[1:0];
          IDX_PITCH:  pitch <= wdata[COORD_W-1:0];
          IDX_BASE:   base <= wdata[ADDR_W-1:0];
          IDX_SRC0:   {sy0, sx0} <= {wdata[Y_LSB +: COORD_W], wdata[COORD_W-1:0]};
          IDX_DST0:   {dy0, dx0} <= {wdata[Y_LSB +: COORD_W], wdata[COORD_W-1:0]};
          IDX_DST1: begin
            {dy1, dx1} <= {wdata[Y_LSB +: COORD_W], wdata[COORD_W-1:0]};
            launch <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(colour) && $stable(rop) && $stable(dx1) && $stable(dy1) && !launch));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err |=> err);
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int COORD_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               step,
  input  logic               backward,
  input  logic [COORD_W-1:0] sx0,
  input  logic [COORD_W-1:0] sy0,
  input  logic [COORD_W-1:0] dx0,
  input  logic [COORD_W-1:0] dy0,
  input  logic [COORD_W-1:0] dx1,
  input  logic [COORD_W-1:0] dy1,
  output logic [COORD_W-1:0] sx,
  output logic [COORD_W-1:0] sy,
  output logic [COORD_W-1:0] dx,
  output logic [COORD_W-1:0] dy,
  output logic               last
);
  logic [COORD_W-1:0] inc;
  logic               row_end;

  assign inc     = backward ? '1 : COORD_W'(1);
  assign row_end = (dx == dx1);
  assign last    = row_end && (dy == dy1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sx <= '0; sy <= '0; dx <= '0; dy <= '0;
    end else if (load) begin
      sx <= sx0; sy <= sy0; dx <= dx0; dy <= dy0;
    end else if (step) begin
      if (row_end) begin
        dx <= dx0;      sx <= sx0;
        dy <= dy + inc; sy <= sy + inc;
      end else begin
        dx <= dx + inc; sx <= sx + inc;
      end
    end
  end

  // R7
  load_step_excl_chk: assert property (@(posedge clk) disable iff (rst) load |-> !step);
endmodule

// File: rtl/blit_rop.sv
module blit_rop
  import blit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        rop,
  input  logic              copy_mode,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] colour,
  output logic              need_dst,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] s_val;

  assign s_val    = copy_mode ? src : colour;
  assign need_dst = (rop == ROP_XOR);

  always_comb begin
    case (rop)
      ROP_XOR: result = s_val ^ dst;
      ROP_PAT: result = colour;
      default: result = s_val;
    endcase
  end
endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int COORD_W   = 16,
  parameter int PIX_BYTES = 4,
  parameter int ADDR_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic [3:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic                   busy,
  output logic                   err,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [PIX_BYTES*8-1:0] mem_wdata,
  input  logic [PIX_BYTES*8-1:0] mem_rdata,
  input  logic                   mem_ack
);
  localparam int DATA_W = PIX_BYTES * 8;

  logic [DATA_W-1:0]  colour, src_q, dst_q, result;
  logic [7:0]         rop;
  logic               copy_mode, backward, launch, need_dst, last, step;
  logic [COORD_W-1:0] pitch, sx0, sy0, dx0, dy0, dx1, dy1, sx, sy, dx, dy;
  logic [ADDR_W-1:0]  base;
  blit_st_e           state_q, first_st;

  blit_regs #(.COORD_W(COORD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .colour(colour), .rop(rop), .copy_mode(copy_mode),
    .backward(backward), .pitch(pitch), .base(base),
    .sx0(sx0), .sy0(sy0), .dx0(dx0), .dy0(dy0), .dx1(dx1), .dy1(dy1),
    .launch(launch), .err(err));

  blit_walker #(.COORD_W(COORD_W)) u_walk (
    .clk(clk), .rst(rst), .load(launch), .step(step), .backward(backward),
    .sx0(sx0), .sy0(sy0), .dx0(dx0), .dy0(dy0), .dx1(dx1), .dy1(dy1),
    .sx(sx), .sy(sy), .dx(dx), .dy(dy), .last(last));

  blit_rop #(.DATA_W(DATA_W)) u_rop (
    .rop(rop), .copy_mode(copy_mode), .src(src_q), .dst(dst_q),
    .colour(colour), .need_dst(need_dst), .result(result));

  function automatic logic [ADDR_W-1:0] pix_addr(input logic [COORD_W-1:0] x,
                                                 input logic [COORD_W-1:0] y);
    logic [ADDR_W-1:0] lin;
    lin = ADDR_W'(y) * ADDR_W'(pitch) + ADDR_W'(x);
    return base + lin * ADDR_W'(PIX_BYTES);
  endfunction

  assign first_st = copy_mode ? ST_RD_S : (need_dst ? ST_RD_D : ST_WR);
  assign step     = (state_q == ST_WR) && mem_ack;
  assign busy     = launch || (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch) state_q <= first_st;
        ST_RD_S: if (mem_ack) begin
          src_q   <= mem_rdata;
          state_q <= need_dst ? ST_RD_D : ST_WR;
        end
        ST_RD_D: if (mem_ack) begin
          dst_q   <= mem_rdata;
          state_q <= ST_WR;
        end
        ST_WR: if (mem_ack) state_q <= last ? ST_IDLE : first_st;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = (state_q == ST_RD_S) ? pix_addr(sx, sy) : pix_addr(dx, dy);
  assign mem_wdata = result;

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(mem_ack && mem_we));
  // R6
  launch_req_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> mem_req);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R11
  rd_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack && busy) |=> (!mem_req || !$past(last) || !busy));
endmodule

// File: tb/sim_blit_engine.sv
`timescale 1ns/1ps
module sim_blit_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        busy, err, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  blit_engine u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .err(err), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  typedef struct { logic we; logic [31:0] addr; logic [31:0] data; } txn_t;
  txn_t exp_q[$];

  logic [31:0] mem   [0:2047];
  logic [31:0] ref_m [0:2047];
  logic [31:0] snap  [0:2047];
  int cur_base  = 32'h100;
  int cur_pitch = 32;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int addr_of(input int x, input int y);
    return cur_base + (y * cur_pitch + x) * 4;
  endfunction

  // memory responder with varying latency, and per-clock busy/transaction comparison
  int  lat_cnt = 0, txn_n = 0;
  bit  prev_busy = 0, prev_wack = 0;
  always @(negedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; prev_busy = 0; prev_wack = 0;
    end else begin
      if (prev_busy && !busy) chk(prev_wack, "R9 busy fall after write ack", 32'(prev_wack), 1);
      prev_busy = busy;
      prev_wack = 0;
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
        if (lat_cnt < txn_n % 3) lat_cnt++;
        else begin
          txn_t e;
          int idx;
          lat_cnt = 0; txn_n++;
          idx = int'(mem_addr >> 2) & 2047;
          if (exp_q.size() == 0) chk(0, "R11 unexpected request", mem_addr, 0);
          else begin
            e = exp_q.pop_front();
            chk(mem_we == e.we, "R11 request kind", 32'(mem_we), 32'(e.we));
            chk(mem_addr == e.addr, "R8/R7 request address", mem_addr, e.addr);
            if (e.we) chk(mem_wdata == e.data, "R3/R4/R5 write data", mem_wdata, e.data);
          end
          mem_rdata <= mem[idx];
          if (mem_we) begin mem[idx] = mem_wdata; prev_wack = 1; end
          mem_ack <= 1'b1;
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
  endtask

  // behavioural model of the pixel walk: expected transactions and final memory
  task automatic model(input bit cp, input bit bw, input int sx0, input int sy0,
                       input int dx0, input int dy0, input int dx1, input int dy1,
                       input logic [7:0] rop, input logic [31:0] col);
    int s = bw ? -1 : 1;
    int nc = (dx1 - dx0) * s + 1;
    int nr = (dy1 - dy0) * s + 1;
    for (int r = 0; r < nr; r++)
      for (int c = 0; c < nc; c++) begin
        int sa = addr_of(sx0 + s*c, sy0 + s*r);
        int da = addr_of(dx0 + s*c, dy0 + s*r);
        logic [31:0] sv, dv, res;
        sv = cp ? ref_m[sa>>2] : col;
        if (cp) exp_q.push_back('{1'b0, 32'(sa), 32'h0});
        dv = ref_m[da>>2];
        if (rop == 8'h66) exp_q.push_back('{1'b0, 32'(da), 32'h0});
        res = (rop == 8'h66) ? (sv ^ dv) : (rop == 8'hF0) ? col : sv;
        exp_q.push_back('{1'b1, 32'(da), res});
        ref_m[da>>2] = res;
      end
  endtask

  // check the whole rectangle against pre-operation memory, and a one-pixel ring outside
  task automatic check_rect(input bit cp, input int sx, input int sy, input int dx, input int dy,
                            input int w, input int h, input logic [7:0] rop,
                            input logic [31:0] col, input string req);
    int bad = 0;
    logic [31:0] first_act = 0, first_exp = 0;
    for (int y = dy - 1; y <= dy + h; y++)
      for (int x = dx - 1; x <= dx + w; x++) begin
        if (x >= 0 && y >= 0 && x < cur_pitch) begin
          logic [31:0] e, sv, dv;
          int da = addr_of(x, y) >> 2;
          if (x >= dx && x < dx + w && y >= dy && y < dy + h) begin
            sv = cp ? snap[addr_of(sx + x - dx, sy + y - dy) >> 2] : col;
            dv = snap[da];
            e = (rop == 8'h66) ? (sv ^ dv) : (rop == 8'hF0) ? col : sv;
          end else e = snap[da];
          if (mem[da] !== e) begin
            if (bad == 0) begin first_act = mem[da]; first_exp = e; end
            bad++;
          end
        end
      end
    chk(bad == 0, req, first_act, first_exp);
  endtask

  task automatic run_op(input bit cp, input int sx, input int sy, input int dx, input int dy,
                        input int w, input int h, input logic [7:0] rop,
                        input logic [31:0] col, input string req);
    bit bw;
    int s0x, s0y, d0x, d0y, d1x, d1y;
    bw = cp && !((sy > dy) || (sy == dy && sx > dx));
    if (bw) begin
      s0x = sx + w - 1; s0y = sy + h - 1; d0x = dx + w - 1; d0y = dy + h - 1; d1x = dx; d1y = dy;
    end else begin
      s0x = sx; s0y = sy; d0x = dx; d0y = dy; d1x = dx + w - 1; d1y = dy + h - 1;
    end
    for (int i = 0; i < 2048; i++) snap[i] = mem[i];
    model(cp, bw, s0x, s0y, d0x, d0y, d1x, d1y, rop, col);
    wr(4'd0, col);
    wr(4'd1, 32'(rop));
    wr(4'd2, {30'd0, bw, cp});
    wr(4'd5, {16'(s0y), 16'(s0x)});                       // R1 packing
    wr(4'd6, {16'(d0y), 16'(d0x)});
    chk(busy == 1'b0, "R6 no launch before last corner", 32'(busy), 0);
    wr(4'd7, {16'(d1y), 16'(d1x)});
    chk(busy == 1'b1, "R9 busy rises after launch", 32'(busy), 1);
    wait_idle();
    @(negedge clk);
    chk(exp_q.size() == 0, "R11 all transactions seen", 32'(exp_q.size()), 0);
    check_rect(cp, sx, sy, dx, dy, w, h, rop, col, req);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i] = 32'(i) * 32'h9E3779B1;
      ref_m[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0, "reset busy", 32'(busy), 0);
    chk(err == 0, "reset err", 32'(err), 0);
    chk(mem_req == 0, "reset mem_req", 32'(mem_req), 0);

    wr(4'd3, 32);
    wr(4'd4, 32'h100);
    // R2 R3 fill, inclusive corners, ring untouched
    run_op(0, 0, 0, 2, 1, 3, 2, 8'hCC, 32'h11223344, "R2 R3 fill source copy");
    // R5 pattern code, single pixel
    run_op(0, 0, 0, 7, 7, 1, 1, 8'hF0, 32'hCAFEF00D, "R5 fill pattern one pixel");
    // R4 XOR fill reads destination
    run_op(0, 0, 0, 4, 5, 4, 3, 8'h66, 32'h0F0F00FF, "R4 fill xor");
    // R3 unknown code treated as source
    run_op(0, 0, 0, 10, 2, 2, 2, 8'h00, 32'h5A5A5A5A, "R3 fill unknown code");
    // R7 copies: forward, overlapping backward, same-row both sides
    run_op(1, 1, 20, 3, 10, 5, 4, 8'hCC, 32'h0, "R7 copy forward disjoint");
    run_op(1, 10, 10, 12, 12, 6, 5, 8'hCC, 32'h0, "R7 overlap copy backward");
    run_op(1, 14, 15, 12, 13, 6, 5, 8'hCC, 32'h0, "R7 overlap copy forward");
    run_op(1, 5, 25, 8, 25, 10, 2, 8'hCC, 32'h0, "R7 same row src left backward");
    run_op(1, 9, 28, 6, 28, 10, 2, 8'hCC, 32'h0, "R7 same row src right forward");
    run_op(1, 2, 2, 20, 3, 3, 3, 8'h66, 32'h0, "R4 copy xor");
    run_op(1, 2, 2, 20, 8, 3, 2, 8'hF0, 32'h13579BDF, "R5 copy pattern");
    // R8 different base and pitch
    cur_base = 32'h200; cur_pitch = 24;
    wr(4'd3, 24);
    wr(4'd4, 32'h200);
    run_op(1, 0, 5, 3, 2, 4, 3, 8'hCC, 32'h0, "R8 base and pitch change");

    // R10 writes while busy ignored, err sticky
    for (int i = 0; i < 2048; i++) snap[i] = mem[i];
    model(0, 0, 1, 1, 1, 1, 6, 3, 8'hCC, 32'hA1A2A3A4);
    wr(4'd0, 32'hA1A2A3A4); wr(4'd1, 32'hCC); wr(4'd2, 0);
    wr(4'd6, {16'd1, 16'd1});
    wr(4'd7, {16'd3, 16'd6});
    chk(err == 0, "R10 err clear before conflict", 32'(err), 0);
    wr(4'd0, 32'hDEADBEEF);
    wr(4'd7, {16'd9, 16'd9});
    chk(err == 1, "R10 err set by write while busy", 32'(err), 1);
    wait_idle();
    repeat (6) @(negedge clk);
    chk(busy == 0, "R10 ignored launch starts nothing", 32'(busy), 0);
    chk(exp_q.size() == 0, "R10 no extra transactions", 32'(exp_q.size()), 0);
    check_rect(0, 0, 0, 1, 1, 6, 3, 8'hCC, 32'hA1A2A3A4, "R10 colour unchanged by busy write");
    // relaunch with no colour rewrite: colour register must still hold old value
    for (int i = 0; i < 2048; i++) snap[i] = mem[i];
    model(0, 0, 1, 8, 1, 8, 2, 9, 8'hCC, 32'hA1A2A3A4);
    wr(4'd6, {16'd8, 16'd1});
    wr(4'd7, {16'd9, 16'd2});
    wait_idle();
    @(negedge clk);
    check_rect(0, 0, 0, 1, 8, 2, 2, 8'hCC, 32'hA1A2A3A4, "R10 register kept old value");
    chk(err == 1, "R10 err sticky", 32'(err), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule